// File: doc/BRIEF.md
# Receive Phase Alignment Sequencer

This block sequences phase alignment for one receive lane of a serial transceiver that runs with its elastic buffer bypassed. It watches four event strobes: receiver reset or power-up, PLL reset or power-up, a change of the recovered clock's source or frequency, and a line-rate change. Any of them means the receive clock domain has to be aligned again. The block then waits until the lane's clock-stable qualifier has been high for a settle interval. After that it drives the combined phase/delay alignment start output for a fixed number of cycles and waits for the alignment-done status to rise.

Once the done status has risen, the lane counts as aligned. The block then stays quiet, because delay alignment keeps tracking voltage and temperature without help. Two cases count as a broken handshake: done falls while the lane is aligned, or done never rises within a timeout. In either case the block pulses the receiver reset, adds one to a saturating error counter and runs a new alignment. Events that arrive while an alignment is in flight are remembered, and they cause exactly one extra alignment once the current one finishes.

Top module: `rx_phalign_seq`

## Requirements
- R1: While `rst` is high and after it is released, `align_start_o`, `rx_reset_o` and `aligned_o` are low and `err_count_o` is zero, until an event strobe arrives.
- R2: A one-cycle pulse on any of the four event inputs, seen while idle or while aligned, clears `aligned_o` on the next cycle and begins a new alignment.
- R3: `align_start_o` rises only after `clk_stable_i` has been high for SETTLE_CYCLES consecutive clock edges. Any low cycle of `clk_stable_i` restarts that count.
- R4: Each alignment start holds `align_start_o` high for exactly START_CYCLES cycles.
- R5: Completion is declared only on a low-to-high transition of `sync_done_i` after the start pulse has ended. If `sync_done_i` is already high, it must first go low and then high again. `aligned_o` rises on the cycle after that rising edge is sampled.
- R6: While aligned, `sync_done_i` stays high and no event arrives, `aligned_o` stays high and `align_start_o` stays low.
- R7: If `sync_done_i` is sampled low while aligned, then on the next cycle `rx_reset_o` goes high for exactly RESET_CYCLES cycles and `err_count_o` increases by one. After the reset pulse, a new settle and start follow. A drop of done takes priority over an event in the same cycle.
- R8: If no rising edge of `sync_done_i` arrives within TIMEOUT_CYCLES cycles after the start pulse ends, the block starts the same recovery as R7: a reset pulse, an error count and a new alignment.
- R9: Event strobes that arrive during the start pulse or while waiting for done queue a single restart. When done then rises, the block returns to the settle phase instead of declaring alignment.
- R10: `err_count_o` increases by one per recovery and saturates at 2^ERR_W-1. It never wraps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| evt_rx_reset_i | input | 1 | Strobe: receiver reset or power-up |
| evt_pll_reset_i | input | 1 | Strobe: PLL reset or power-up |
| evt_clk_change_i | input | 1 | Strobe: recovered clock source or frequency changed |
| evt_rate_change_i | input | 1 | Strobe: line rate changed |
| sync_done_i | input | 1 | Alignment-done status from the lane |
| clk_stable_i | input | 1 | Lane clocks stable qualifier |
| align_start_o | output | 1 | Phase/delay alignment start, held START_CYCLES cycles |
| rx_reset_o | output | 1 | Receiver reset pulse, held RESET_CYCLES cycles |
| aligned_o | output | 1 | Lane is aligned |
| err_count_o | output | ERR_W | Saturating count of handshake violations |

## Verification
The bench measures each pulse and wait length at the ports. It targets the done input that is already high when the start pulse begins: a design that tested the level would report alignment at once and never see the required low-high transition. A drop of done while aligned must produce a reset pulse of exact length and a single error step. A timeout counted from the wrong point would show up as a wrong number of cycles before the reset rises. An event slipped in while waiting for done must cause a second start, and a design without the queue would settle into the aligned state. A long chain of timeouts drives the error counter past its ceiling, which exposes any wrap to zero.

// File: rtl/rxpa_pkg.sv
package rxpa_pkg;

    localparam int unsigned NUM_EVT = 4;

    typedef enum logic [2:0] {
        ST_IDLE        = 3'd0,
        ST_WAIT_STABLE = 3'd1,
        ST_START       = 3'd2,
        ST_WAIT_DONE   = 3'd3,
        ST_ALIGNED     = 3'd4,
        ST_RECOVER     = 3'd5
    } rxpa_state_e;

    typedef struct packed {
        logic start;
        logic rx_reset;
        logic aligned;
    } rxpa_out_t;

    function automatic rxpa_out_t decode_outputs(rxpa_state_e s);
        rxpa_out_t o;
        o.start    = (s == ST_START);
        o.rx_reset = (s == ST_RECOVER);
        o.aligned  = (s == ST_ALIGNED);
        return o;
    endfunction

    function automatic int unsigned max2(int unsigned a, int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/rxpa_trigger.sv
module rxpa_trigger #(
    parameter int unsigned N = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] evt_i,
    input  logic         queue_en_i,
    input  logic         clear_i,
    output logic         any_o,
    output logic         pending_o
);
    logic pend_q;

    assign any_o     = |evt_i;
    assign pending_o = pend_q;

    always_ff @(posedge clk) begin
        if (rst)
            pend_q <= 1'b0;
        else if (clear_i)
            pend_q <= 1'b0;
        else if (queue_en_i && any_o)
            pend_q <= 1'b1;
    end
endmodule

// File: rtl/rxpa_edge.sv
module rxpa_edge (
    input  logic clk,
    input  logic rst,
    input  logic level_i,
    output logic rise_o
);
    logic lvl_q;

    always_ff @(posedge clk) begin
        if (rst)
            lvl_q <= 1'b0;
        else
            lvl_q <= level_i;
    end

    assign rise_o = level_i & ~lvl_q;
endmodule

// File: rtl/rxpa_sat_ctr.sv
module rxpa_sat_ctr #(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         inc_i,
    output logic [W-1:0] count_o
);
    logic [W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst)
            cnt_q <= '0;
        else if (inc_i && (cnt_q != {W{1'b1}}))
            cnt_q <= cnt_q + 1'b1;
    end

    assign count_o = cnt_q;
endmodule

// File: rtl/rx_phalign_seq.sv
module rx_phalign_seq
    import rxpa_pkg::*;
#(
    parameter int unsigned SETTLE_CYCLES  = 16,
    parameter int unsigned START_CYCLES   = 4,
    parameter int unsigned TIMEOUT_CYCLES = 65536,
    parameter int unsigned RESET_CYCLES   = 8,
    parameter int unsigned ERR_W          = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             evt_rx_reset_i,
    input  logic             evt_pll_reset_i,
    input  logic             evt_clk_change_i,
    input  logic             evt_rate_change_i,
    input  logic             sync_done_i,
    input  logic             clk_stable_i,
    output logic             align_start_o,
    output logic             rx_reset_o,
    output logic             aligned_o,
    output logic [ERR_W-1:0] err_count_o
);
    localparam int unsigned LIM_MAX = max2(max2(SETTLE_CYCLES, START_CYCLES),
                                           max2(TIMEOUT_CYCLES, RESET_CYCLES));
    localparam int unsigned TW = $clog2(LIM_MAX) + 1;
    localparam logic [TW-1:0] SETTLE_LAST  = TW'(SETTLE_CYCLES - 1);
    localparam logic [TW-1:0] START_LAST   = TW'(START_CYCLES - 1);
    localparam logic [TW-1:0] TIMEOUT_LAST = TW'(TIMEOUT_CYCLES - 1);
    localparam logic [TW-1:0] RESET_LAST   = TW'(RESET_CYCLES - 1);

    rxpa_state_e   st_q, st_d;
    logic [TW-1:0] tmr_q, tmr_d;
    logic [NUM_EVT-1:0] evt_vec;
    logic          evt_any, pend, sd_rise, err_inc, enter_ws, queue_en;
    rxpa_out_t     outs;

    assign evt_vec  = {evt_rate_change_i, evt_clk_change_i, evt_pll_reset_i, evt_rx_reset_i};
    assign queue_en = (st_q == ST_START) || (st_q == ST_WAIT_DONE);
    assign enter_ws = (st_d == ST_WAIT_STABLE) && (st_q != ST_WAIT_STABLE);

    rxpa_trigger #(.N(NUM_EVT)) u_trig (
        .clk        (clk),
        .rst        (rst),
        .evt_i      (evt_vec),
        .queue_en_i (queue_en),
        .clear_i    (enter_ws),
        .any_o      (evt_any),
        .pending_o  (pend)
    );

    rxpa_edge u_edge (
        .clk     (clk),
        .rst     (rst),
        .level_i (sync_done_i),
        .rise_o  (sd_rise)
    );

    rxpa_sat_ctr #(.W(ERR_W)) u_err (
        .clk     (clk),
        .rst     (rst),
        .inc_i   (err_inc),
        .count_o (err_count_o)
    );

    always_comb begin
        st_d    = st_q;
        tmr_d   = tmr_q + 1'b1;
        err_inc = 1'b0;
        case (st_q)
            ST_IDLE: begin
                tmr_d = '0;
                if (evt_any) st_d = ST_WAIT_STABLE;
            end
            ST_WAIT_STABLE: begin
                if (!clk_stable_i)              tmr_d = '0;
                else if (tmr_q == SETTLE_LAST)  st_d  = ST_START;
            end
            ST_START: begin
                if (tmr_q == START_LAST) st_d = ST_WAIT_DONE;
            end
            ST_WAIT_DONE: begin
                if (sd_rise) begin
                    st_d = (pend || evt_any) ? ST_WAIT_STABLE : ST_ALIGNED;
                end else if (tmr_q == TIMEOUT_LAST) begin
                    st_d    = ST_RECOVER;
                    err_inc = 1'b1;
                end
            end
            ST_ALIGNED: begin
                tmr_d = '0;
                if (!sync_done_i) begin
                    st_d    = ST_RECOVER;
                    err_inc = 1'b1;
                end else if (evt_any) begin
                    st_d = ST_WAIT_STABLE;
                end
            end
            ST_RECOVER: begin
                if (tmr_q == RESET_LAST) st_d = ST_WAIT_STABLE;
            end
            default: begin
                st_d  = ST_IDLE;
                tmr_d = '0;
            end
        endcase
        if (st_d != st_q) tmr_d = '0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q  <= ST_IDLE;
            tmr_q <= '0;
        end else begin
            st_q  <= st_d;
            tmr_q <= tmr_d;
        end
    end

    assign outs          = decode_outputs(st_q);
    assign align_start_o = outs.start;
    assign rx_reset_o    = outs.rx_reset;
    assign aligned_o     = outs.aligned;
endmodule

// File: rtl/rxpa_checker.sv
module rxpa_checker #(
    parameter int unsigned ERR_W = 8
) (
    input logic             clk,
    input logic             rst,
    input logic             evt_rx_reset_i,
    input logic             evt_pll_reset_i,
    input logic             evt_clk_change_i,
    input logic             evt_rate_change_i,
    input logic             sync_done_i,
    input logic             clk_stable_i,
    input logic             align_start_o,
    input logic             rx_reset_o,
    input logic             aligned_o,
    input logic [ERR_W-1:0] err_count_o
);
    logic any_evt;
    assign any_evt = evt_rx_reset_i | evt_pll_reset_i | evt_clk_change_i | evt_rate_change_i;

    assert_start_needs_stable_R3: assert property (@(posedge clk) disable iff (rst)
        $rose(align_start_o) |-> $past(clk_stable_i));

    assert_align_on_rise_R5: assert property (@(posedge clk) disable iff (rst)
        $rose(aligned_o) |-> ($past(sync_done_i) && !$past(sync_done_i, 2)));

    assert_quiet_when_locked_R6: assert property (@(posedge clk) disable iff (rst)
        (aligned_o && sync_done_i && !any_evt) |=> (aligned_o && !align_start_o));

    assert_drop_recovers_R7: assert property (@(posedge clk) disable iff (rst)
        (aligned_o && !sync_done_i) |=> rx_reset_o);

    assert_reset_counts_R7: assert property (@(posedge clk) disable iff (rst)
        $rose(rx_reset_o) |-> ((err_count_o == $past(err_count_o) + 1'b1) ||
                               ($past(err_count_o) == {ERR_W{1'b1}})));

    assert_err_step_R10: assert property (@(posedge clk) disable iff (rst)
        !$stable(err_count_o) |-> (err_count_o == $past(err_count_o) + 1'b1));
endmodule

bind rx_phalign_seq rxpa_checker #(.ERR_W(ERR_W)) u_rxpa_chk (
    .clk               (clk),
    .rst               (rst),
    .evt_rx_reset_i    (evt_rx_reset_i),
    .evt_pll_reset_i   (evt_pll_reset_i),
    .evt_clk_change_i  (evt_clk_change_i),
    .evt_rate_change_i (evt_rate_change_i),
    .sync_done_i       (sync_done_i),
    .clk_stable_i      (clk_stable_i),
    .align_start_o     (align_start_o),
    .rx_reset_o        (rx_reset_o),
    .aligned_o         (aligned_o),
    .err_count_o       (err_count_o)
);

// File: tb/rx_phalign_seq_bench.sv
module rx_phalign_seq_bench;
    localparam int SETTLE  = 4;
    localparam int STARTC  = 4;
    localparam int TMO     = 64;
    localparam int RSTC    = 8;
    localparam int EW      = 8;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [3:0] evt = 4'b0;
    logic sync_done = 1'b0;
    logic clk_stable = 1'b1;
    logic align_start, rx_reset, aligned;
    logic [EW-1:0] err_count;

    int n_cmp = 0;
    int n_bad = 0;
    int exp_err = 0;
    bit done_flag = 1'b0;

    always #2 clk = ~clk;

    rx_phalign_seq #(
        .SETTLE_CYCLES(SETTLE), .START_CYCLES(STARTC), .TIMEOUT_CYCLES(TMO),
        .RESET_CYCLES(RSTC), .ERR_W(EW)
    ) u_rx_phalign_seq (
        .clk(clk), .rst(rst),
        .evt_rx_reset_i(evt[0]), .evt_pll_reset_i(evt[1]),
        .evt_clk_change_i(evt[2]), .evt_rate_change_i(evt[3]),
        .sync_done_i(sync_done), .clk_stable_i(clk_stable),
        .align_start_o(align_start), .rx_reset_o(rx_reset),
        .aligned_o(aligned), .err_count_o(err_count)
    );

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input string req, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic logic sig(input int which);
        case (which)
            0: return align_start;
            1: return rx_reset;
            default: return aligned;
        endcase
    endfunction

    task automatic wait_for(input int which, input logic val, input int lim, output int n);
        n = 0;
        while (sig(which) !== val && n < lim) begin
            tick();
            n++;
        end
    endtask

    task automatic pulse_evt(input int k);
        evt[k] = 1'b1;
        tick();
        evt = 4'b0;
    endtask

    task automatic t_reset();
        rst = 1'b1;
        repeat (3) tick();
        chk("R1 start during reset", int'(align_start), 0);
        rst = 1'b0;
        repeat (5) tick();
        chk("R1 start idle", int'(align_start), 0);
        chk("R1 rxreset idle", int'(rx_reset), 0);
        chk("R1 aligned idle", int'(aligned), 0);
        chk("R1 err idle", int'(err_count), 0);
        exp_err = 0;
    endtask

    task automatic t_normal();
        int n;
        sync_done = 1'b0;
        clk_stable = 1'b1;
        pulse_evt(0);
        wait_for(0, 1'b1, 100, n);
        chk("R3 settle length", n, SETTLE);
        wait_for(0, 1'b0, 100, n);
        chk("R4 start length", n, STARTC);
        repeat (3) tick();
        chk("R5 not aligned before rise", int'(aligned), 0);
        sync_done = 1'b1;
        tick();
        chk("R5 aligned after rise", int'(aligned), 1);
        repeat (40) begin
            tick();
            if (align_start !== 1'b0 || aligned !== 1'b1)
                chk("R6 quiet while aligned", int'(align_start), 0);
        end
        chk("R6 still aligned", int'(aligned), 1);
    endtask

    task automatic t_already_high(input int k);
        int n;
        pulse_evt(k);
        chk("R2 event drops aligned", int'(aligned), 0);
        wait_for(0, 1'b1, 100, n);
        chk("R2 event starts alignment", n, SETTLE);
        wait_for(0, 1'b0, 100, n);
        repeat (5) tick();
        chk("R5 level high is not completion", int'(aligned), 0);
        sync_done = 1'b0;
        tick();
        chk("R5 still waiting after low", int'(aligned), 0);
        sync_done = 1'b1;
        tick();
        chk("R5 aligned after low-high", int'(aligned), 1);
    endtask

    task automatic t_drop();
        int n;
        sync_done = 1'b0;
        evt[3] = 1'b1;
        tick();
        evt = 4'b0;
        exp_err++;
        chk("R7 reset after drop", int'(rx_reset), 1);
        chk("R7 err step", int'(err_count), exp_err);
        wait_for(1, 1'b0, 100, n);
        chk("R7 reset length", n, RSTC);
        wait_for(0, 1'b1, 100, n);
        chk("R7 realign after reset", n, SETTLE);
        wait_for(0, 1'b0, 100, n);
        sync_done = 1'b1;
        tick();
        chk("R7 aligned again", int'(aligned), 1);
    endtask

    task automatic t_timeout();
        int n;
        pulse_evt(1);
        sync_done = 1'b0;
        wait_for(0, 1'b1, 100, n);
        wait_for(0, 1'b0, 100, n);
        wait_for(1, 1'b1, 1000, n);
        exp_err++;
        chk("R8 timeout length", n, TMO);
        chk("R8 err step", int'(err_count), exp_err);
        wait_for(1, 1'b0, 100, n);
        wait_for(0, 1'b1, 100, n);
        chk("R8 restart after timeout", n, SETTLE);
        wait_for(0, 1'b0, 100, n);
        sync_done = 1'b1;
        tick();
        chk("R8 aligned after recovery", int'(aligned), 1);
    endtask

    task automatic t_stable_gate();
        int n;
        clk_stable = 1'b0;
        pulse_evt(2);
        repeat (20) tick();
        chk("R3 no start while unstable", int'(align_start), 0);
        clk_stable = 1'b1;
        repeat (2) tick();
        clk_stable = 1'b0;
        tick();
        clk_stable = 1'b1;
        wait_for(0, 1'b1, 100, n);
        chk("R3 count restarts after glitch", n, SETTLE);
        wait_for(0, 1'b0, 100, n);
        sync_done = 1'b0;
        tick();
        sync_done = 1'b1;
        tick();
        chk("R3 aligned after gated start", int'(aligned), 1);
    endtask

    task automatic t_queue();
        int n;
        pulse_evt(0);
        sync_done = 1'b0;
        wait_for(0, 1'b1, 100, n);
        wait_for(0, 1'b0, 100, n);
        tick();
        pulse_evt(3);
        tick();
        sync_done = 1'b1;
        tick();
        chk("R9 queued event blocks aligned", int'(aligned), 0);
        wait_for(0, 1'b1, 100, n);
        chk("R9 second start", n, SETTLE);
        wait_for(0, 1'b0, 100, n);
        sync_done = 1'b0;
        tick();
        sync_done = 1'b1;
        tick();
        chk("R9 aligned after second pass", int'(aligned), 1);
        chk("R9 no errors from queue", int'(err_count), exp_err);
    endtask

    task automatic t_saturate();
        sync_done = 1'b0;
        tick();
        exp_err++;
        repeat (270 * (SETTLE + STARTC + TMO + RSTC)) tick();
        chk("R10 saturated count", int'(err_count), 255);
        repeat (2 * (SETTLE + STARTC + TMO + RSTC)) tick();
        chk("R10 no wrap", int'(err_count), 255);
        rst = 1'b1;
        repeat (3) tick();
        rst = 1'b0;
        tick();
        chk("R1 reset clears err", int'(err_count), 0);
        chk("R1 reset clears reset out", int'(rx_reset), 0);
    endtask

    initial begin
        t_reset();
        t_normal();
        for (int k = 0; k < 4; k++) t_already_high(k);
        t_drop();
        t_timeout();
        t_stable_gate();
        t_queue();
        t_saturate();
        if (!done_flag) begin
            done_flag = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done_flag) begin
            done_flag = 1'b1;
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule